// File: doc/BRIEF.md
# Elastic Bit Store with Collision Windows

This block is the bit-wide elastic store inside a receive-side jitter attenuator. Recovered line bits are written on a write strobe. The same bits come back out, in order, on a read strobe that a smoothed clock generates. Both strobes are qualified enables of one synchronous clock domain. The store holds either 32 or 64 bits, and the read side starts out half a store behind the write side, so the nominal latency is half the depth.

The block watches the distance between its two pointers. It raises a status flag when the pointers come within three positions of meeting, from either side. It asks the smoothing loop to open up its bandwidth when they come within two positions, so that the loop follows short-term input jitter instead of letting the store slip. It also decodes the loop rate code from the line-standard and bandwidth inputs. On the E1 standard, picking the slow rate forces the deep store. On T1 the bandwidth input is ignored and the rate is fixed.

Top module: `elastic_jitter_fifo`

## Requirements
- R1: `depth_64` is 1 (64-bit store) when `depth_sel` is 1, or when `line_t1` is 0 and `bw_sel` is 1. Otherwise it is 0 (32-bit store). It reflects the inputs sampled at the previous clock edge.
- R2: `rate_code` is 2'b10 (3 Hz) whenever `line_t1` is 1, whatever `bw_sel` is. With `line_t1` 0 it is 2'b01 (1.5 Hz) for `bw_sel` 1 and 2'b00 (10 Hz) for `bw_sel` 0. It follows the inputs of the previous edge.
- R3: After a synchronous reset, `sep_level` equals half the active depth, `rd_bit` is 0, and the prefilled half of the store reads back as zeros.
- R4: Bits read out on `rd_bit` (updated on the edge where `rd_en` is 1) appear in write order, after the prefilled bits.
- R5: `limit_flag` is 1 exactly when `sep_level` <= 3 or `sep_level` >= depth-3.
- R6: `wide_bw` is 1 exactly when `sep_level` <= 2 or `sep_level` >= depth-2. It stays 1 until the separation leaves that window, and it is never 1 while `limit_flag` is 0.
- R7: `sep_level` is the write pointer minus the read pointer, modulo the active depth. A lone write adds one, a lone read subtracts one, and a write with a read leaves it unchanged.
- R8: On the edge after the active depth changes, both pointers are recentred (`sep_level` = new depth/2, store cleared), and strobes presented on that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read strobes |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one recovered bit |
| wr_bit | input | 1 | Recovered bit to store |
| rd_en | input | 1 | Read strobe from the smoothed clock |
| rd_bit | output | 1 | Last bit read from the store |
| depth_sel | input | 1 | 1 asks for the 64-bit store |
| line_t1 | input | 1 | 1 selects the T1 standard, 0 selects E1 |
| bw_sel | input | 1 | On E1: 1 selects 1.5 Hz, 0 selects 10 Hz |
| depth_64 | output | 1 | Active depth, 1 means 64 bits |
| rate_code | output | 2 | Loop rate: 00 10 Hz, 01 1.5 Hz, 10 3 Hz |
| sep_level | output | 6 | Pointer separation modulo active depth |
| limit_flag | output | 1 | Pointers within three positions of meeting |
| wide_bw | output | 1 | Request for wide loop bandwidth |

## Verification
The bench drives the store to one entry short of full and down to empty at both depths, so the three- and two-position windows are crossed at both ends. A comparator written against the wrong depth, or with an off-by-one margin, would then show up as a flag that differs from the model at the turning point. Depth changes are forced through the E1 slow-rate selection and through `depth_sel`. A design that did not recentre, or that let a strobe through on the changing edge, would read stale or shifted bits. On T1 the bench toggles `bw_sel` while data flows. A design that honoured it there would change depth, recentre, and lose data.

// File: rtl/efb_pkg.sv
package efb_pkg;

    typedef enum logic [1:0] {
        RATE_10HZ  = 2'b00,
        RATE_1P5HZ = 2'b01,
        RATE_3HZ   = 2'b10
    } rate_code_e;

    typedef struct packed {
        logic wr;
        logic bit_in;
        logic rd;
    } strobe_t;

    typedef struct packed {
        logic       deep;
        rate_code_e rate;
    } loop_cfg_t;

    function automatic loop_cfg_t decode_cfg(input logic depth_req,
                                             input logic is_t1,
                                             input logic slow_bw);
        loop_cfg_t c;
        c.deep = depth_req | (~is_t1 & slow_bw);
        if (is_t1)
            c.rate = RATE_3HZ;
        else if (slow_bw)
            c.rate = RATE_1P5HZ;
        else
            c.rate = RATE_10HZ;
        return c;
    endfunction

endpackage

// File: rtl/efb_rate_sel.sv
module efb_rate_sel
    import efb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      depth_sel,
    input  logic      line_t1,
    input  logic      bw_sel,
    output loop_cfg_t cfg_next,
    output loop_cfg_t cfg_q
);
    assign cfg_next = decode_cfg(depth_sel, line_t1, bw_sel);

    always_ff @(posedge clk) begin
        cfg_q <= cfg_next;
    end

    // R2: on T1 the registered rate is the fixed code, whatever bw_sel did
    assert_t1_rate_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        line_t1 |=> (cfg_q.rate == RATE_3HZ));

    // R1: on E1 the slow rate always comes with the deep store
    assert_slow_forces_deep_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rate == RATE_1P5HZ) |-> cfg_q.deep);
endmodule

// File: rtl/efb_store.sv
module efb_store
    import efb_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_next,
    input  logic              deep_q,
    input  strobe_t           stb,
    output logic              rd_bit,
    output logic [ADDR_W-1:0] sep
);
    localparam int unsigned DEPTH_MAX = 1 << ADDR_W;
    localparam int unsigned DEPTH_MIN = DEPTH_MAX / 2;

    logic [DEPTH_MAX-1:0] mem;
    logic [ADDR_W-1:0]    wptr;
    logic [ADDR_W-1:0]    rptr;
    logic [ADDR_W-1:0]    mask_q;
    logic [ADDR_W-1:0]    mask_next;
    logic [ADDR_W-1:0]    half_next;
    logic                 recentre;

    assign recentre  = rst | (deep_next != deep_q);
    assign mask_q    = deep_q    ? ADDR_W'(DEPTH_MAX - 1) : ADDR_W'(DEPTH_MIN - 1);
    assign mask_next = deep_next ? ADDR_W'(DEPTH_MAX - 1) : ADDR_W'(DEPTH_MIN - 1);
    assign half_next = deep_next ? ADDR_W'(DEPTH_MAX / 2) : ADDR_W'(DEPTH_MIN / 2);

    assign sep = (wptr - rptr) & mask_q;

    always_ff @(posedge clk) begin
        if (recentre) begin
            mem  <= '0;
            wptr <= '0;
            rptr <= (ADDR_W'(0) - half_next) & mask_next;
            if (rst)
                rd_bit <= 1'b0;
        end else begin
            if (stb.rd) begin
                rd_bit <= mem[rptr];
                rptr   <= (rptr + 1'b1) & mask_q;
            end
            if (stb.wr) begin
                mem[wptr] <= stb.bit_in;
                wptr      <= (wptr + 1'b1) & mask_q;
            end
        end
    end

    // R3, R8: a recentre leaves the pointers half the new depth apart
    assert_recentre_half_R8: assert property (@(posedge clk) disable iff (rst)
        (deep_next != deep_q) |=> (sep == (deep_q ? ADDR_W'(DEPTH_MAX / 2) : ADDR_W'(DEPTH_MIN / 2))));

    // R7: a lone write moves the separation up by one, modulo depth
    assert_write_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!recentre && stb.wr && !stb.rd) |=> (sep == (($past(sep) + 1'b1) & $past(mask_q))));

    // R7: a lone read moves the separation down by one, modulo depth
    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!recentre && !stb.wr && stb.rd) |=> (sep == (($past(sep) - 1'b1) & $past(mask_q))));

    // R7: a paired write and read leave the separation unchanged
    assert_pair_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!recentre && stb.wr && stb.rd) |=> $stable(sep));
endmodule

// File: rtl/efb_window.sv
module efb_window #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned MARGIN = 3
) (
    input  logic [ADDR_W-1:0] sep,
    input  logic              deep,
    output logic              near
);
    localparam int unsigned DEPTH_MAX = 1 << ADDR_W;
    localparam int unsigned DEPTH_MIN = DEPTH_MAX / 2;

    logic [ADDR_W:0] depth_now;
    logic [ADDR_W:0] sep_ext;

    assign depth_now = deep ? (ADDR_W+1)'(DEPTH_MAX) : (ADDR_W+1)'(DEPTH_MIN);
    assign sep_ext   = {1'b0, sep};

    assign near = (sep_ext <= (ADDR_W+1)'(MARGIN)) ||
                  (sep_ext >= depth_now - (ADDR_W+1)'(MARGIN));
endmodule

// File: rtl/elastic_jitter_fifo.sv
module elastic_jitter_fifo
    import efb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned FLAG_MARGIN = 3,
    parameter int unsigned WIDE_MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              rd_en,
    output logic              rd_bit,
    input  logic              depth_sel,
    input  logic              line_t1,
    input  logic              bw_sel,
    output logic              depth_64,
    output logic [1:0]        rate_code,
    output logic [ADDR_W-1:0] sep_level,
    output logic              limit_flag,
    output logic              wide_bw
);
    localparam int unsigned N_WIN = 2;
    localparam int unsigned MARGINS [N_WIN] = '{FLAG_MARGIN, WIDE_MARGIN};

    loop_cfg_t         cfg_next;
    loop_cfg_t         cfg_q;
    strobe_t           stb;
    logic [N_WIN-1:0]  near;

    assign stb = '{wr: wr_en, bit_in: wr_bit, rd: rd_en};

    efb_rate_sel u_rate (
        .clk       (clk),
        .rst       (rst),
        .depth_sel (depth_sel),
        .line_t1   (line_t1),
        .bw_sel    (bw_sel),
        .cfg_next  (cfg_next),
        .cfg_q     (cfg_q)
    );

    efb_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .deep_next (cfg_next.deep),
        .deep_q    (cfg_q.deep),
        .stb       (stb),
        .rd_bit    (rd_bit),
        .sep       (sep_level)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        efb_window #(.ADDR_W(ADDR_W), .MARGIN(MARGINS[g])) u_win (
            .sep  (sep_level),
            .deep (cfg_q.deep),
            .near (near[g])
        );
    end

    assign limit_flag = near[0];
    assign wide_bw    = near[1];
    assign depth_64   = cfg_q.deep;
    assign rate_code  = cfg_q.rate;

    // R6: the bandwidth request sits inside the status window
    assert_wide_inside_limit_R6: assert property (@(posedge clk) disable iff (rst)
        wide_bw |-> limit_flag);

    // R6: the request only drops when the separation has moved
    assert_wide_release_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(wide_bw) && $stable(depth_64)) |-> !$stable(sep_level));
endmodule

// File: tb/test_elastic_jitter_fifo.sv
module test_elastic_jitter_fifo;
    logic       clk = 1'b0;
    logic       rst, wr_en, wr_bit, rd_en, depth_sel, line_t1, bw_sel;
    logic       rd_bit, depth_64, limit_flag, wide_bw;
    logic [1:0] rate_code;
    logic [5:0] sep_level;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    bit   q[$];
    bit   m_deep, m_rd;
    int   m_rate;

    always #5 clk = ~clk;

    elastic_jitter_fifo i_elastic_jitter_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .depth_sel(depth_sel), .line_t1(line_t1), .bw_sel(bw_sel),
        .depth_64(depth_64), .rate_code(rate_code), .sep_level(sep_level),
        .limit_flag(limit_flag), .wide_bw(wide_bw)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int depth_now();
        return m_deep ? 64 : 32;
    endfunction

    task automatic prefill();
        q.delete();
        for (int i = 0; i < depth_now() / 2; i++) q.push_back(1'b0);
    endtask

    task automatic compare_all();
        int d  = depth_now();
        int s  = q.size();
        chk(depth_64 == m_deep, "R1 depth", depth_64, m_deep);
        chk(rate_code == m_rate, "R2 rate", rate_code, m_rate);
        chk(sep_level == s, "R7 separation", sep_level, s);
        chk(rd_bit == m_rd, "R4 read data order", rd_bit, m_rd);
        chk(limit_flag == ((s <= 3) || (s >= d - 3)), "R5 limit window", limit_flag,
            (s <= 3) || (s >= d - 3));
        chk(wide_bw == ((s <= 2) || (s >= d - 2)), "R6 wide window", wide_bw,
            (s <= 2) || (s >= d - 2));
    endtask

    // One clock: apply inputs at a falling edge, update the model, check at the next falling edge
    task automatic step(input int pw, input int pr, input bit ds, input bit t1, input bit bw);
        bit w, r, b, nd;
        w  = (($urandom % 100) < pw) && (q.size() < depth_now() - 1);
        r  = (($urandom % 100) < pr) && (q.size() > 0);
        b  = $urandom % 2;
        wr_en = w; rd_en = r; wr_bit = b;
        depth_sel = ds; line_t1 = t1; bw_sel = bw;
        nd = ds | (!t1 & bw);
        m_rate = t1 ? 2 : (bw ? 1 : 0);
        if (nd != m_deep) begin
            m_deep = nd;
            prefill();
        end else begin
            if (r) m_rd = q.pop_front();
            if (w) q.push_back(b);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input int n, input int pw, input int pr, input bit ds, input bit t1, input bit bw);
        for (int i = 0; i < n; i++) step(pw, pr, ds, t1, bw);
    endtask

    task automatic do_reset(input bit ds, input bit t1, input bit bw);
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0; wr_bit = 0;
        depth_sel = ds; line_t1 = t1; bw_sel = bw;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_deep = ds | (!t1 & bw);
        m_rate = t1 ? 2 : (bw ? 1 : 0);
        m_rd = 1'b0;
        prefill();
        chk(sep_level == depth_now() / 2, "R3 reset centre", sep_level, depth_now() / 2);
        chk(rd_bit == 1'b0, "R3 reset read bit", rd_bit, 0);
        compare_all();
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; wr_bit = 0;
        depth_sel = 0; line_t1 = 0; bw_sel = 0;

        // R3: reset at 32 bits on E1, drain the zero prefill (R4)
        do_reset(0, 0, 0);
        run(40, 0, 100, 0, 0, 0);
        // R5, R6: fill to the top, dwell, drain to empty, dwell
        run(300, 90, 10, 0, 0, 0);
        run(300, 10, 90, 0, 0, 0);
        run(300, 50, 50, 0, 0, 0);

        // R1, R8: slow E1 rate forces 64 bits and recentres
        step(100, 100, 0, 0, 1);
        chk(sep_level == 32, "R8 recentre on deepening", sep_level, 32);
        run(400, 90, 10, 0, 0, 1);
        run(400, 10, 90, 0, 0, 1);
        run(200, 50, 50, 0, 0, 1);

        // R8: back to 32 bits
        step(100, 100, 0, 0, 0);
        chk(sep_level == 16, "R8 recentre on shallowing", sep_level, 16);
        run(200, 70, 30, 0, 0, 0);

        // R2: on T1 bw_sel is ignored, depth stays 32 with no recentre
        step(60, 40, 0, 1, 1);
        for (int i = 0; i < 200; i++) step(60, 45, 0, 1, i % 3 == 0);
        chk(depth_64 == 1'b0, "R2 bw ignored on T1", depth_64, 0);
        run(300, 15, 85, 0, 1, 1);

        // R1: depth_sel asks for 64 bits on T1
        step(100, 100, 1, 1, 0);
        chk(sep_level == 32, "R8 recentre via depth_sel", sep_level, 32);
        run(400, 95, 5, 1, 1, 0);
        run(400, 5, 95, 1, 1, 1);

        // R3: reset mid-stream into 64 bits on E1
        do_reset(1, 0, 0);
        run(300, 60, 40, 1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule